// File: doc/BRIEF.md
# Phase-Triggered Prefetch Tuning Controller

This controller picks the parameter set that a hardware prefetcher runs with and searches for a better one each time the running program enters a new phase. An external detector sends a one-cycle phase-change pulse and a level that reports when the program has settled. A trial tick marks the end of each measurement window. A score input carries the figure of merit measured for the candidate that is currently applied.

After a phase change the controller waits for the program to settle. It then applies each of `NUM_CFG` candidate configurations in turn, for one tick-delimited window each, and records the score that arrives with each tick. When the last candidate has been measured, it locks the best-scoring index and holds it until the next phase change. A phase change that arrives in the middle of a search abandons that search. The outputs are the applied configuration index and the controller state.

Top module: `prefetch_phase_tuner`

## Requirements
- R1: While reset is asserted, and for the first cycles after it is released, the state output reads 0 (settled), the configuration index reads 0, and the state output never takes the value 3.
- R2: In the settled state (0), a phase-change pulse moves the state to 1 (waiting) on the next cycle, and the configuration index does not change.
- R3: In the settled state with no phase-change pulse, the state and the configuration index hold, whatever the tick, the stability level and the score are doing.
- R4: In the waiting state (1) the controller stays put until the stability level is high. Ticks are ignored and the configuration index holds.
- R5: In the waiting state, a high stability level with no phase-change pulse enters the search state (2) on the next cycle with configuration index 0 applied.
- R6: In the search state, each tick advances the applied index by one on the next cycle, and the index holds in cycles without a tick.
- R7: The tick that arrives while the last index (`NUM_CFG`-1) is applied returns the state to 0 on the next cycle. The index then applied is the candidate with the highest unsigned 16-bit score sampled during that search, the last candidate's score included.
- R8: When several candidates share the highest score, the lowest index among them is locked.
- R9: A phase-change pulse in the search state returns the state to 1 on the next cycle, even when a tick arrives in the same cycle. The applied index reverts to the one locked before the search began.
- R10: In the waiting state, a phase-change pulse keeps the controller waiting even when the stability level is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| phase_chg_i | input | 1 | One-cycle pulse marking a new program phase |
| stable_i | input | 1 | High when the program is reported as settled |
| tick_i | input | 1 | End of a trial window; the score is sampled in this cycle |
| score_i | input | 16 | Unsigned score of the configuration applied during the window |
| cfg_idx_o | output | 3 | Index of the configuration applied to the prefetcher |
| state_o | output | 2 | 0 settled, 1 waiting, 2 searching |

## Verification
Every state and index change becomes visible one clock after the edge that samples the causing input. The exception is reset, whose assertion acts at once and whose release takes two further edges through the synchronizer. The bench drives inputs at the falling edge. Its reference model advances at the rising edge from the same held inputs, and both outputs are compared at the next falling edge, so each result is checked exactly in the cycle it is due. The locked winner is additionally checked against a fixed expected index at the cycle where the search ends.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef enum logic [1:0] {
    PTC_STABLE   = 2'd0,
    PTC_UNSTABLE = 2'd1,
    PTC_TUNING   = 2'd2
  } ptc_state_e;
endpackage

// File: rtl/ptc_fsm.sv
module ptc_fsm
  import ptc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phase_chg,
  input  logic       settled,
  input  logic       tick,
  input  logic       last_trial,
  output ptc_state_e state,
  output logic       start,
  output logic       finish
);
  ptc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    start   = 1'b0;
    finish  = 1'b0;
    case (state_q)
      PTC_STABLE: begin
        if (phase_chg) state_d = PTC_UNSTABLE;
      end
      PTC_UNSTABLE: begin
        if (!phase_chg && settled) begin
          state_d = PTC_TUNING;
          start   = 1'b1;
        end
      end
      PTC_TUNING: begin
        if (phase_chg) begin
          state_d = PTC_UNSTABLE;
        end else if (tick && last_trial) begin
          state_d = PTC_STABLE;
          finish  = 1'b1;
        end
      end
      default: state_d = PTC_STABLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PTC_STABLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/ptc_trial_ctr.sv
module ptc_trial_ctr #(
  parameter int NUM_CFG = 8,
  localparam int IdxW = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv,
  output logic [IdxW-1:0] idx,
  output logic            last
);
  localparam logic [IdxW-1:0] LastIdx = IdxW'(NUM_CFG - 1);

  logic [IdxW-1:0] idx_q, idx_d;
  logic            idx_en;

  assign idx_en = clr | adv;
  assign idx_d  = clr ? '0 : idx_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx  = idx_q;
  assign last = (idx_q == LastIdx);
endmodule

// File: rtl/ptc_best_track.sv
module ptc_best_track #(
  parameter int NUM_CFG = 8,
  parameter int SCORE_W = 16,
  localparam int IdxW = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample,
  input  logic [IdxW-1:0]    idx,
  input  logic [SCORE_W-1:0] score,
  output logic [IdxW-1:0]    win_idx
);
  logic [SCORE_W-1:0] best_score_q;
  logic [IdxW-1:0]    best_idx_q;
  logic               take;

  // first candidate always seeds; later ones must be strictly better
  assign take = sample && ((idx == '0) || (score > best_score_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_score_q <= '0;
      best_idx_q   <= '0;
    end else if (take) begin
      best_score_q <= score;
      best_idx_q   <= idx;
    end
  end

  assign win_idx = take ? idx : best_idx_q;
endmodule

// File: rtl/prefetch_phase_tuner.sv
module prefetch_phase_tuner
  import ptc_pkg::*;
#(
  parameter int NUM_CFG = 8,
  parameter int SCORE_W = 16,
  localparam int IDX_W = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               phase_chg_i,
  input  logic               stable_i,
  input  logic               tick_i,
  input  logic [SCORE_W-1:0] score_i,
  output logic [IDX_W-1:0]   cfg_idx_o,
  output logic [1:0]         state_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  ptc_state_e       state;
  logic             start, finish, last_trial;
  logic             in_tuning, trial_sample, trial_adv;
  logic [IDX_W-1:0] trial_idx, win_idx, active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign in_tuning    = (state == PTC_TUNING);
  assign trial_sample = in_tuning & tick_i & ~phase_chg_i;
  assign trial_adv    = trial_sample & ~last_trial;

  ptc_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .phase_chg  (phase_chg_i),
    .settled    (stable_i),
    .tick       (tick_i),
    .last_trial (last_trial),
    .state      (state),
    .start      (start),
    .finish     (finish)
  );

  ptc_trial_ctr #(.NUM_CFG(NUM_CFG)) u_ctr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (start),
    .adv   (trial_adv),
    .idx   (trial_idx),
    .last  (last_trial)
  );

  ptc_best_track #(.NUM_CFG(NUM_CFG), .SCORE_W(SCORE_W)) u_best (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sample  (trial_sample),
    .idx     (trial_idx),
    .score   (score_i),
    .win_idx (win_idx)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  active_q <= '0;
    else if (finish) active_q <= win_idx;
  end

  assign cfg_idx_o = in_tuning ? trial_idx : active_q;
  assign state_o   = state;
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
  parameter int NUM_CFG = 8,
  localparam int IDX_W = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             phase_chg_i,
  input logic             stable_i,
  input logic             tick_i,
  input logic [IDX_W-1:0] cfg_idx_o,
  input logic [1:0]       state_o
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(NUM_CFG - 1);

  p_legal_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'd3);

  p_phase_leaves_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && phase_chg_i) |=> (state_o == 2'd1 && $stable(cfg_idx_o)));

  p_stable_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && !phase_chg_i) |=> (state_o == 2'd0 && $stable(cfg_idx_o)));

  p_wait_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && (phase_chg_i || !stable_i)) |=> (state_o == 2'd1 && $stable(cfg_idx_o)));

  p_enter_search_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && stable_i && !phase_chg_i) |=> (state_o == 2'd2 && cfg_idx_o == '0));

  p_trial_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && !phase_chg_i && tick_i && cfg_idx_o != LastIdx)
      |=> (state_o == 2'd2 && cfg_idx_o == IDX_W'($past(cfg_idx_o) + 1'b1)));

  p_trial_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && !phase_chg_i && !tick_i) |=> (state_o == 2'd2 && $stable(cfg_idx_o)));

  p_search_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && !phase_chg_i && tick_i && cfg_idx_o == LastIdx) |=> (state_o == 2'd0));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && phase_chg_i) |=> (state_o == 2'd1));
endmodule

bind prefetch_phase_tuner ptc_checker #(.NUM_CFG(NUM_CFG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .phase_chg_i (phase_chg_i),
  .stable_i    (stable_i),
  .tick_i      (tick_i),
  .cfg_idx_o   (cfg_idx_o),
  .state_o     (state_o)
);

// File: tb/sim_prefetch_phase_tuner.sv
`timescale 1ns/1ps
module sim_prefetch_phase_tuner;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        phase_chg_i, stable_i, tick_i;
  logic [15:0] score_i;
  logic [2:0]  cfg_idx_o;
  logic [1:0]  state_o;

  int checks = 0;
  int bad    = 0;
  bit done   = 1'b0;

  // reference model state
  int m_state  = 0;
  int m_active = 0;
  int m_trial  = 0;
  int m_scores[$];

  always #2 clk = ~clk;

  prefetch_phase_tuner u0 (
    .clk(clk), .rst_n(rst_n), .phase_chg_i(phase_chg_i), .stable_i(stable_i),
    .tick_i(tick_i), .score_i(score_i), .cfg_idx_o(cfg_idx_o), .state_o(state_o)
  );

  function automatic int m_cfg();
    return (m_state == 2) ? m_trial : m_active;
  endfunction

  function automatic int pick_best();
    int b = 0;
    foreach (m_scores[i]) if (m_scores[i] > m_scores[b]) b = i;
    return b;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (state_o !== 2'(m_state) || cfg_idx_o !== 3'(m_cfg())) begin
      bad++;
      $display("FAIL %s: state=%0d cfg=%0d expected state=%0d cfg=%0d",
               tag, state_o, cfg_idx_o, m_state, m_cfg());
    end
  endtask

  task automatic expect_lock(input int exp, input string tag);
    checks++;
    if (state_o !== 2'd0 || cfg_idx_o !== 3'(exp)) begin
      bad++;
      $display("FAIL %s: state=%0d cfg=%0d expected state=0 cfg=%0d",
               tag, state_o, cfg_idx_o, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after comparing
  task automatic step(input bit ph, input bit st, input bit tk, input int sc, input string tag);
    phase_chg_i = ph; stable_i = st; tick_i = tk; score_i = 16'(sc);
    @(posedge clk);
    case (m_state)
      0: if (ph) m_state = 1;
      1: if (!ph && st) begin m_state = 2; m_trial = 0; m_scores.delete(); end
      2: if (ph) m_state = 1;
         else if (tk) begin
           m_scores.push_back(sc);
           if (m_trial == N - 1) begin m_active = pick_best(); m_state = 0; end
           else m_trial++;
         end
      default: ;
    endcase
    @(negedge clk);
    compare(tag);
  endtask

  task automatic search(input int sc[N], input int gap, input string tag);
    for (int i = 0; i < N; i++) begin
      for (int g = 0; g < gap; g++) step(0, (g % 2) == 0, 0, 16'hFFFF, "R6");
      step(0, 1, 1, sc[i], tag);
    end
  endtask

  task automatic hard_reset();
    rst_n = 1'b0;
    #1;
    m_state = 0; m_active = 0; m_trial = 0;
    compare("R1");
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R1");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int s1[N]   = '{10, 40, 5, 40, 99, 99, 3, 0};
    int s2[N]   = '{7, 7, 7, 7, 7, 7, 7, 7};
    int s3[N]   = '{1, 2, 3, 4, 5, 6, 7, 65535};
    int s4[N]   = '{0, 0, 0, 0, 0, 0, 0, 0};
    phase_chg_i = 0; stable_i = 0; tick_i = 0; score_i = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R1");

    // R3: noise in the settled state
    step(0, 1, 1, 500, "R3");
    step(0, 0, 1, 9, "R3");
    step(0, 1, 0, 0, "R3");

    // R2, R4, R10
    step(1, 0, 0, 0, "R2");
    step(0, 0, 1, 123, "R4");
    step(0, 0, 1, 7, "R4");
    step(1, 1, 0, 0, "R10");
    step(1, 1, 1, 0, "R10");

    // R5 then a full search with gaps; tie at 99 between index 4 and 5
    step(0, 1, 0, 0, "R5");
    search(s1, 1, "R6");
    expect_lock(4, "R7/R8 tie of 99 keeps index 4");

    // R9: abort mid-search with a tick in the same cycle
    step(1, 0, 0, 0, "R2");
    step(0, 1, 0, 0, "R5");
    step(0, 1, 1, 60000, "R6");
    step(0, 1, 1, 60000, "R6");
    step(1, 1, 1, 60000, "R9");
    checks++;
    if (state_o !== 2'd1 || cfg_idx_o !== 3'd4) begin
      bad++;
      $display("FAIL R9: state=%0d cfg=%0d expected state=1 cfg=4", state_o, cfg_idx_o);
    end
    step(0, 0, 1, 0, "R4");

    // R8: all equal -> 0, back-to-back ticks
    step(0, 1, 0, 0, "R5");
    search(s2, 0, "R6");
    expect_lock(0, "R8 all equal locks index 0");

    // R7: winner is the last candidate
    step(1, 0, 0, 0, "R2");
    step(0, 1, 0, 0, "R5");
    search(s3, 2, "R6");
    expect_lock(7, "R7 last candidate wins");
    step(0, 1, 1, 0, "R3");

    // R8: all zero
    step(1, 0, 0, 0, "R2");
    step(0, 1, 0, 0, "R5");
    search(s4, 0, "R6");
    expect_lock(0, "R8 all zero locks index 0");

    // R1: reset in the middle of a search
    step(1, 0, 0, 0, "R2");
    step(0, 1, 0, 0, "R5");
    step(0, 1, 1, 3, "R6");
    hard_reset();
    step(0, 1, 1, 3, "R3");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule